// File: doc/BRIEF.md
# PS/2 Host Receive Engine

This block listens to one PS/2 device on the clock and data lines and captures every frame the device sends. Both lines are resynchronised to the system clock and cleaned by a short majority filter. After that a two-state engine takes one data sample in each low phase of the device clock. It then waits for the clock to rise again before it accepts the next bit. Eleven bits make one frame. The raw frame is written into a circular buffer, and the block raises a one-cycle strobe and a sticky ready flag.

A consumer reads the buffer through a simple pop port. One pop removes the oldest entry. One cycle later the block returns the data byte and a flag that shows whether the stored parity bit breaks odd parity. The block always shows how many entries are waiting, and this count stays correct when the pointers wrap. If the device clock stays high too long in the middle of a frame, the partial frame is dropped, so the next frame starts from bit 0 again.

Top module: `ps2_host_rx`

## Requirements
- R1: Each line passes through a synchroniser and a 4-sample window. The filtered level falls only when at most 1 of the 4 samples is high, and rises only when at least 3 are high. A low glitch of one system cycle on the device clock captures no bit.
- R2: The engine takes exactly one data sample per filtered clock low phase. It places the samples LSB first, so frame bit 0 is the start bit, bits 8:1 are the data byte (bit 1 is the data LSB), bit 9 is parity and bit 10 is the stop bit. A frame is committed when the clock rises after the 11th low phase.
- R3: Each committed frame is stored at the write pointer. The write pointer then advances by one and wraps from DEPTH-1 to 0, and entries are returned in the order they arrived.
- R4: Each stored frame gives exactly one single-cycle pulse on `frame_stb` and sets `rx_ready`. `rx_ready` stays high until `rx_ack` is asserted with no new frame in the same cycle.
- R5: A pop while entries are waiting sets `pop_valid` for one cycle in the next cycle. In that cycle `pop_data` holds bits 8:1 of the oldest entry, and the read pointer advances with wrap.
- R6: `pop_perr` is 1 exactly when stored bit 9 equals the XOR of the data byte, which means the 9 bits 9:1 hold an even number of ones (odd parity is broken).
- R7: `avail_count` equals write minus read when read is at most write. Otherwise it equals DEPTH minus read plus write. It never exceeds DEPTH-1.
- R8: A pop while `avail_count` is 0 leaves `pop_valid` low and does not change `avail_count`.
- R9: A frame that completes while DEPTH-1 entries are held is dropped. No `frame_stb` is raised, `avail_count` does not change, and the stored entries are kept.
- R10: When `timeout_cycles` is non-zero and the filtered clock stays high for more than `timeout_cycles` cycles in the middle of a frame, the partial frame is discarded. When `timeout_cycles` is 0, a frame may pause for any length of time.
- R11: After reset `avail_count` is 0, and `rx_ready`, `frame_stb` and `pop_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Device clock line level |
| ps2_dat_i | input | 1 | Device data line level |
| timeout_cycles | input | TO_W | Mid-frame clock-high limit in system cycles, 0 disables |
| rx_ack | input | 1 | Clears the ready flag |
| pop_req | input | 1 | Remove the oldest buffered entry |
| frame_stb | output | 1 | One-cycle pulse per stored frame |
| rx_ready | output | 1 | Sticky flag, at least one frame stored since the last acknowledge |
| pop_valid | output | 1 | Pop result valid |
| pop_data | output | 8 | Data byte of the popped entry |
| pop_perr | output | 1 | Parity error of the popped entry |
| avail_count | output | $clog2(DEPTH)+1 | Entries waiting in the buffer |

## Verification
The bench builds the block with DEPTH set to 8 and a 12-bit timeout, with the default 2-stage synchroniser and 4-sample window. With only 8 slots, a sweep of all 256 data bytes takes both pointers around the ring 32 times, and every third byte carries deliberately wrong parity. The small depth also lets the bench fill the buffer, force a dropped frame and reach the state where read is above write in a few dozen frames. Further runs cover single-cycle clock glitches, and a paused partial frame with the timeout set and with it disabled. In the disabled case the bench computes by hand the spliced frame that the block must produce.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

   localparam int FRAME_BITS = 11;
   localparam int LAST_BIT   = FRAME_BITS - 1;
   localparam int BITCNT_W   = $clog2(FRAME_BITS + 1);

   typedef logic [FRAME_BITS-1:0] frame_t;

   typedef enum logic {
      ST_WAIT_LOW  = 1'b0,
      ST_WAIT_HIGH = 1'b1
   } rx_state_e;

   // odd parity over data byte + parity bit is violated
   function automatic logic parity_broken(input frame_t f);
      return f[9] == (^f[8:1]);
   endfunction

endpackage

// File: rtl/ps2rx_line_filter.sv
module ps2rx_line_filter #(
   parameter int   SYNC_STAGES = 2,
   parameter int   WIN         = 4,
   parameter logic IDLE_LEVEL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   localparam int ONES_W  = $clog2(WIN + 1);
   localparam int RISE_AT = WIN / 2 + 1;
   localparam int FALL_AT = (WIN + 1) / 2;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("ps2rx_line_filter: SYNC_STAGES must be at least 2");
      end
      if (WIN < 3) begin : g_bad_win
         $error("ps2rx_line_filter: WIN must be at least 3");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic [WIN-1:0]         win_q;
   logic [ONES_W-1:0]      ones;
   logic                   level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
         win_q  <= {WIN{IDLE_LEVEL}};
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
         win_q  <= {win_q[WIN-2:0], sync_q[SYNC_STAGES-1]};
      end
   end

   always_comb begin
      ones = '0;
      for (int i = 0; i < WIN; i++) begin
         ones = ones + ONES_W'(win_q[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= IDLE_LEVEL;
      end else if (ones >= ONES_W'(RISE_AT)) begin
         level_q <= 1'b1;
      end else if (ones < ONES_W'(FALL_AT)) begin
         level_q <= 1'b0;
      end
   end

   assign line_o = level_q;

   // R1: a fall needs a window that is mostly low
   p_fall_needs_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (level_q && ones < ONES_W'(FALL_AT)) |=> !level_q);

endmodule

// File: rtl/ps2rx_bit_engine.sv
module ps2rx_bit_engine
   import ps2rx_pkg::*;
#(
   parameter int TO_W       = 16,
   parameter bit TIMEOUT_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clk_f,
   input  logic            dat_f,
   input  logic [TO_W-1:0] timeout_cycles,
   output logic            frame_stb,
   output frame_t          frame_q
);

   generate
      if (TO_W < 2) begin : g_bad_to
         $error("ps2rx_bit_engine: TO_W must be at least 2");
      end
   endgenerate

   rx_state_e            state;
   logic [BITCNT_W-1:0]  bit_cnt;
   frame_t               shreg;
   logic                 to_expire;

   generate
      if (TIMEOUT_EN) begin : g_timeout
         logic [TO_W-1:0] to_cnt;
         logic            stalled;

         assign stalled   = (state == ST_WAIT_LOW) && clk_f && (bit_cnt != '0);
         assign to_expire = stalled && (timeout_cycles != '0) &&
                            (to_cnt == timeout_cycles);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               to_cnt <= '0;
            end else if (!stalled || to_expire) begin
               to_cnt <= '0;
            end else begin
               to_cnt <= to_cnt + TO_W'(1);
            end
         end
      end else begin : g_no_timeout
         logic unused_to;
         assign unused_to = ^timeout_cycles;
         assign to_expire = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_WAIT_LOW;
         bit_cnt   <= '0;
         shreg     <= '0;
         frame_q   <= '0;
         frame_stb <= 1'b0;
      end else begin
         frame_stb <= 1'b0;
         unique case (state)
            ST_WAIT_LOW: begin
               if (!clk_f) begin
                  shreg[bit_cnt] <= dat_f;
                  state          <= ST_WAIT_HIGH;
               end else if (to_expire) begin
                  bit_cnt <= '0;
                  shreg   <= '0;
               end
            end
            ST_WAIT_HIGH: begin
               if (clk_f) begin
                  state <= ST_WAIT_LOW;
                  if (bit_cnt == BITCNT_W'(LAST_BIT)) begin
                     frame_q   <= shreg;
                     frame_stb <= 1'b1;
                     bit_cnt   <= '0;
                     shreg     <= '0;
                  end else begin
                     bit_cnt <= bit_cnt + BITCNT_W'(1);
                  end
               end
            end
            default: state <= ST_WAIT_LOW;
         endcase
      end
   end

   // R2: counter never passes the stop bit position
   p_bitcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= BITCNT_W'(LAST_BIT));

   // R2: no second sample while the clock is still low
   p_one_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_HIGH && !clk_f) |=> $stable(bit_cnt));

   // R4: commit strobe lasts one cycle
   p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> !frame_stb);

   // R10: an expired timeout restarts the frame
   p_timeout_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      to_expire |=> (bit_cnt == '0));

endmodule

// File: rtl/ps2rx_ring.sv
module ps2rx_ring
   import ps2rx_pkg::*;
#(
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  frame_t           wr_frame,
   input  logic             pop_req,
   output logic             stored,
   output logic             pop_valid,
   output logic [7:0]       pop_data,
   output logic             pop_perr,
   output logic [CNT_W-1:0] avail
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ps2rx_ring: DEPTH must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] MAXF_C  = CNT_W'(DEPTH - 1);

   frame_t           mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic [PTR_W-1:0] wr_next, rd_next;
   logic             full, empty;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wr_next = wr_ptr + PTR_W'(1);
         assign rd_next = rd_ptr + PTR_W'(1);
      end else begin : g_cmp_wrap
         assign wr_next = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
         assign rd_next = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
      end
   endgenerate

   always_comb begin
      if (rd_ptr <= wr_ptr) begin
         avail = {1'b0, wr_ptr} - {1'b0, rd_ptr};
      end else begin
         avail = DEPTH_C - {1'b0, rd_ptr} + {1'b0, wr_ptr};
      end
   end

   assign full  = (avail == MAXF_C);
   assign empty = (avail == '0);

   always_ff @(posedge clk) begin
      if (wr_stb && !full) begin
         mem[wr_ptr] <= wr_frame;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr    <= '0;
         rd_ptr    <= '0;
         stored    <= 1'b0;
         pop_valid <= 1'b0;
         pop_data  <= '0;
         pop_perr  <= 1'b0;
      end else begin
         stored    <= 1'b0;
         pop_valid <= 1'b0;
         if (wr_stb && !full) begin
            wr_ptr <= wr_next;
            stored <= 1'b1;
         end
         if (pop_req && !empty) begin
            pop_data  <= mem[rd_ptr][8:1];
            pop_perr  <= parity_broken(mem[rd_ptr]);
            rd_ptr    <= rd_next;
            pop_valid <= 1'b1;
         end
      end
   end

   // R7: count bounded by one less than the slot count
   p_avail_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
      avail <= MAXF_C);

   // R8: empty pop has no effect
   p_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && empty && !wr_stb) |=> (!pop_valid && $stable(rd_ptr)));

   // R9: a frame arriving while full leaves the write side alone
   p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && full) |=> ($stable(wr_ptr) && !stored));

   // R3: an accepted frame adds exactly one entry
   p_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !full && !pop_req) |=> (avail == $past(avail) + CNT_W'(1)));

endmodule

// File: rtl/ps2_host_rx.sv
module ps2_host_rx
   import ps2rx_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int TO_W        = 16,
   parameter int SYNC_STAGES = 2,
   parameter int FILT_WIN    = 4,
   parameter bit TIMEOUT_EN  = 1'b1,
   localparam int CNT_W      = $clog2(DEPTH) + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ps2_clk_i,
   input  logic             ps2_dat_i,
   input  logic [TO_W-1:0]  timeout_cycles,
   input  logic             rx_ack,
   input  logic             pop_req,
   output logic             frame_stb,
   output logic             rx_ready,
   output logic             pop_valid,
   output logic [7:0]       pop_data,
   output logic             pop_perr,
   output logic [CNT_W-1:0] avail_count
);

   localparam int N_LINES = 2;

   logic [N_LINES-1:0] raw_lines;
   logic [N_LINES-1:0] filt_lines;
   logic               eng_stb;
   frame_t             eng_frame;
   logic               stored;

   assign raw_lines = {ps2_dat_i, ps2_clk_i};

   generate
      for (genvar g = 0; g < N_LINES; g++) begin : g_line
         ps2rx_line_filter #(
            .SYNC_STAGES (SYNC_STAGES),
            .WIN         (FILT_WIN),
            .IDLE_LEVEL  (1'b1)
         ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
         );
      end
   endgenerate

   ps2rx_bit_engine #(
      .TO_W       (TO_W),
      .TIMEOUT_EN (TIMEOUT_EN)
   ) u_engine (
      .clk            (clk),
      .rst_n          (rst_n),
      .clk_f          (filt_lines[0]),
      .dat_f          (filt_lines[1]),
      .timeout_cycles (timeout_cycles),
      .frame_stb      (eng_stb),
      .frame_q        (eng_frame)
   );

   ps2rx_ring #(
      .DEPTH (DEPTH)
   ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (eng_stb),
      .wr_frame  (eng_frame),
      .pop_req   (pop_req),
      .stored    (stored),
      .pop_valid (pop_valid),
      .pop_data  (pop_data),
      .pop_perr  (pop_perr),
      .avail     (avail_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_ready <= 1'b0;
      end else if (stored) begin
         rx_ready <= 1'b1;
      end else if (rx_ack) begin
         rx_ready <= 1'b0;
      end
   end

   assign frame_stb = stored;

   // R4: the flag holds until acknowledged
   p_ready_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ready && !rx_ack) |=> rx_ready);

   // R4: every stored frame raises the flag
   p_ready_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      frame_stb |=> rx_ready);

endmodule

// File: tb/tb_ps2_host_rx.sv
module tb_ps2_host_rx;
   localparam int DEPTH = 8;
   localparam int TO_W  = 12;
   localparam int CW    = $clog2(DEPTH) + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ps2_clk_i = 1'b1;
   logic            ps2_dat_i = 1'b1;
   logic [TO_W-1:0] timeout_cycles = TO_W'(100);
   logic            rx_ack = 1'b0;
   logic            pop_req = 1'b0;
   logic            frame_stb, rx_ready, pop_valid, pop_perr;
   logic [7:0]      pop_data;
   logic [CW-1:0]   avail_count;

   int n_tests = 0;
   int n_fail  = 0;
   int stb_cnt = 0;
   bit finished = 0;

   logic [10:0] mq [DEPTH];
   int mw = 0;
   int mr = 0;

   always #10 clk = ~clk;

   ps2_host_rx #(.DEPTH(DEPTH), .TO_W(TO_W)) dut (
      .clk(clk), .rst_n(rst_n), .ps2_clk_i(ps2_clk_i), .ps2_dat_i(ps2_dat_i),
      .timeout_cycles(timeout_cycles), .rx_ack(rx_ack), .pop_req(pop_req),
      .frame_stb(frame_stb), .rx_ready(rx_ready), .pop_valid(pop_valid),
      .pop_data(pop_data), .pop_perr(pop_perr), .avail_count(avail_count));

   always @(negedge clk) if (rst_n && frame_stb) stb_cnt++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int model_avail();
      return (mr <= mw) ? (mw - mr) : (DEPTH - mr + mw);
   endfunction

   function automatic logic [10:0] make_frame(input logic [7:0] d, input bit good);
      logic p;
      p = good ? ~(^d) : (^d);
      return {1'b1, p, d, 1'b0};
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bits(input logic [10:0] f, input int lo, input int hi);
      for (int i = lo; i <= hi; i++) begin
         ps2_dat_i = f[i];
         cyc(4);
         ps2_clk_i = 1'b0;
         cyc(8);
         ps2_clk_i = 1'b1;
         cyc(4);
      end
      ps2_dat_i = 1'b1;
   endtask

   // expected push into the model; returns 1 when it must be stored
   function automatic bit model_push(input logic [10:0] f);
      if (model_avail() < DEPTH - 1) begin
         mq[mw] = f;
         mw = (mw + 1) % DEPTH;
         return 1'b1;
      end
      return 1'b0;
   endfunction

   task automatic send_frame(input logic [10:0] f, input string req);
      int s0;
      bit exp_store;
      s0 = stb_cnt;
      send_bits(f, 0, 10);
      cyc(30);
      exp_store = model_push(f);
      chk(stb_cnt == s0 + int'(exp_store), req, stb_cnt - s0, int'(exp_store));
      chk(int'(avail_count) == model_avail(), "R7 count", int'(avail_count), model_avail());
   endtask

   task automatic do_pop(input string req);
      bit ev;
      logic [10:0] f;
      ev = (model_avail() != 0);
      f = mq[mr];
      pop_req = 1'b1;
      cyc(1);
      pop_req = 1'b0;
      chk(pop_valid == ev, req, int'(pop_valid), int'(ev));
      if (ev) begin
         mr = (mr + 1) % DEPTH;
         chk(pop_data == f[8:1], "R5 data", int'(pop_data), int'(f[8:1]));
         chk(pop_perr == (f[9] == ^f[8:1]), "R6 parity flag", int'(pop_perr),
             int'(f[9] == ^f[8:1]));
      end
      cyc(1);
      chk(pop_valid == 1'b0, "R5 one-cycle valid", int'(pop_valid), 0);
      chk(int'(avail_count) == model_avail(), "R7 count after pop", int'(avail_count),
          model_avail());
   endtask

   task automatic do_ack();
      rx_ack = 1'b1;
      cyc(1);
      rx_ack = 1'b0;
      chk(rx_ready == 1'b0, "R4 ack clears", int'(rx_ready), 0);
   endtask

   initial begin
      logic [10:0] fa, fc, splice;
      cyc(5);
      // R11 reset state
      chk(avail_count == '0, "R11 avail", int'(avail_count), 0);
      chk(rx_ready == 1'b0, "R11 ready", int'(rx_ready), 0);
      chk(pop_valid == 1'b0, "R11 valid", int'(pop_valid), 0);
      chk(frame_stb == 1'b0, "R11 stb", int'(frame_stb), 0);
      rst_n = 1'b1;
      cyc(5);
      // R8 empty pop
      do_pop("R8 empty pop");

      // R2 R3 R5 R6: all bytes, every third one with wrong parity, ring wraps
      for (int b = 0; b < 256; b++) begin
         send_frame(make_frame(b[7:0], (b % 3) != 0), "R2 frame strobe");
         chk(rx_ready == 1'b1, "R4 ready set", int'(rx_ready), 1);
         do_ack();
         do_pop("R3 pop order");
      end

      // R1 single-cycle glitches on an idle clock
      for (int g = 0; g < 5; g++) begin
         ps2_clk_i = 1'b0;
         cyc(1);
         ps2_clk_i = 1'b1;
         cyc(6);
      end
      cyc(20);
      chk(avail_count == '0, "R1 glitch ignored", int'(avail_count), 0);
      send_frame(make_frame(8'hA5, 1'b1), "R1 frame after glitches");
      do_pop("R1 pop after glitches");

      // R9 fill to DEPTH-1, one dropped frame, then wrap with read above write
      for (int k = 0; k < DEPTH - 1; k++) send_frame(make_frame(8'(8'h10 + k), 1'b1), "R9 fill");
      send_frame(make_frame(8'hEE, 1'b1), "R9 dropped frame no strobe");
      chk(int'(avail_count) == DEPTH - 1, "R9 count held", int'(avail_count), DEPTH - 1);
      for (int k = 0; k < 5; k++) do_pop("R9 pop kept entries");
      for (int k = 0; k < 4; k++) send_frame(make_frame(8'(8'h60 + k), (k % 2) == 0), "R7 wrap fill");
      chk(int'(avail_count) == model_avail(), "R7 read above write", int'(avail_count), model_avail());
      for (int k = 0; k < 7; k++) do_pop("R7 drain");
      do_ack();

      // R10 timeout discards a partial frame
      fa = make_frame(8'h3C, 1'b1);
      fc = make_frame(8'hC6, 1'b0);
      timeout_cycles = TO_W'(100);
      send_bits(fa, 0, 3);
      cyc(300);
      send_frame(fc, "R10 frame after timeout");
      do_pop("R10 pop clean frame");

      // R10 timeout disabled: the pause is spanned, giving a spliced frame
      timeout_cycles = '0;
      send_bits(fa, 0, 3);
      cyc(300);
      splice = {fc[6:0], fa[3:0]};
      send_bits(fc, 0, 10);
      cyc(30);
      void'(model_push(splice));
      chk(int'(avail_count) == model_avail(), "R10 disabled keeps partial", int'(avail_count),
          model_avail());
      do_pop("R10 spliced frame");
      timeout_cycles = TO_W'(100);
      cyc(300);
      send_frame(make_frame(8'h81, 1'b1), "R10 leftover bits discarded");
      do_pop("R10 pop after recovery");

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule